// File: doc/BRIEF.md
# Interrupt Context Stacking Sequencer

This block runs the processor-side part of taking an interrupt and coming back from it. When a request is accepted at an instruction boundary, it saves the return address and the register file to a byte-wide stack that grows downward. The condition code byte goes last. The block then raises the mask bits, fetches a two-byte vector from memory and hands the new program counter to the core.

A return command runs the sequence the other way. The same nine bytes are read back from the stack, the condition code byte first. The block then presents the restored registers and program counter to the core and replaces its condition code byte with the stacked one. That restores both mask bits to their state before the interrupt.

The block owns the stack pointer and the condition code byte. It also enforces the rule that software can clear the non-maskable mask bit but can never set it. Instruction decode and arbitration between sources sit outside; the block sees a single request with its vector and a flag saying whether it is non-maskable.

Top module: `irq_ctx_stacker`

## Requirements
- R1: After reset the condition code byte is 0x50, with the maskable mask in bit 4 and the non-maskable mask in bit 6 set and all other bits clear. `busy` is low and no memory write is issued.
- R2: A maskable request is ignored while bit 4 is set. A non-maskable request is ignored while bit 6 is set.
- R3: A request is accepted only in a cycle where `insn_done` is high. `busy` rises on the following cycle.
- R4: Entry writes nine bytes, each at the stack pointer minus one, decrementing the pointer per byte. The order is: return address low, return address high, Y low, Y high, X low, X high, A, B, condition code. The pointer finishes nine below its start and points at the condition code byte.
- R5: When stacking completes, bit 4 is set. Bit 6 is set only on a non-maskable entry. Every other condition code bit keeps its value.
- R6: After stacking, the vector high byte is read at the vector address and the low byte at the vector address plus one. `pc_load` pulses with that address on `pc_new`. `busy` stays high for exactly 11 cycles of entry.
- R7: A software condition code write (`ccr_wr`) sets every bit to the written value, except that bit 6 can go from 1 to 0 but never from 0 to 1.
- R8: A return reads nine bytes upward, starting at the stack pointer, in the reverse of the push order, incrementing after each read. The pointer ends at its pre-entry value, and `busy` stays high for exactly 9 cycles.
- R9: In the last return cycle, `regs_load` and `pc_load` pulse with X, Y, A, B and the program counter taken from the stacked bytes. The condition code byte then equals the stacked byte.
- R10: While `busy` is high, new requests, return commands, stack pointer writes and condition code writes have no effect. A return command takes precedence over a request arriving in the same idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_done | input | 1 | Current instruction completes this cycle |
| irq_req | input | 1 | Interrupt request |
| irq_nmi | input | 1 | Request is non-maskable |
| irq_vec | input | ADDR_W | Address of the two-byte vector |
| rti_req | input | 1 | Return-from-interrupt command |
| sp_wr | input | 1 | Load the stack pointer |
| sp_wdata | input | ADDR_W | New stack pointer value |
| sp | output | ADDR_W | Stack pointer |
| ccr_wr | input | 1 | Software condition code write |
| ccr_wdata | input | 8 | Condition code write value |
| ccr | output | 8 | Condition code byte |
| pc_in | input | ADDR_W | Return address to stack |
| x_in | input | 16 | X register |
| y_in | input | 16 | Y register |
| a_in | input | 8 | Accumulator A |
| b_in | input | 8 | Accumulator B |
| pc_load | output | 1 | Load program counter from pc_new |
| pc_new | output | ADDR_W | New program counter |
| regs_load | output | 1 | Load X, Y, A, B from the outputs below |
| x_out | output | 16 | Restored X |
| y_out | output | 16 | Restored Y |
| a_out | output | 8 | Restored A |
| b_out | output | 8 | Restored B |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe, data returned same cycle |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte |
| busy | output | 1 | Entry or return sequence in progress |

## Verification
The bench builds the block with its defaults: a 16-bit address, the maskable mask at bit 4 and the non-maskable mask at bit 6. The full 16-bit width makes the return address high byte and both vector bytes fully significant, so a swapped byte order or a missing stacked byte shows in the restored program counter. The two mask positions leave the low nibble free. That lets the bench push a condition code byte with unrelated bits set and confirm they survive entry and return untouched, while the mask bits rise and fall exactly as required.

// File: rtl/ctx_seq_pkg.sv
package ctx_seq_pkg;
   localparam int unsigned FRAME_BYTES = 9;
   localparam int unsigned SLOT_W      = 4;

   // stack frame slots in push order (slot 0 pushed first)
   localparam int unsigned SLOT_PCL = 0;
   localparam int unsigned SLOT_PCH = 1;
   localparam int unsigned SLOT_YL  = 2;
   localparam int unsigned SLOT_YH  = 3;
   localparam int unsigned SLOT_XL  = 4;
   localparam int unsigned SLOT_XH  = 5;
   localparam int unsigned SLOT_A   = 6;
   localparam int unsigned SLOT_B   = 7;
   localparam int unsigned SLOT_CC  = 8;

   typedef enum logic [2:0] {
      SEQ_IDLE,
      SEQ_PUSH,
      SEQ_VHI,
      SEQ_VLO,
      SEQ_PULL
   } seq_state_e;
endpackage

// File: rtl/ctx_frame.sv
module ctx_frame
   import ctx_seq_pkg::*;
#(
   parameter int unsigned ADDR_W = 16
) (
   input  logic              clk,
   input  logic              snap,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [15:0]       x_in,
   input  logic [15:0]       y_in,
   input  logic [7:0]        a_in,
   input  logic [7:0]        b_in,
   input  logic [7:0]        cc_in,
   input  logic              cap,
   input  logic [SLOT_W-1:0] cap_slot,
   input  logic [7:0]        cap_byte,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic [7:0]        rd_byte,
   output logic [15:0]       x_out,
   output logic [15:0]       y_out,
   output logic [7:0]        a_out,
   output logic [7:0]        b_out,
   output logic [7:0]        cc_out,
   output logic [7:0]        pc_hi
);
   logic [15:0] pc16;
   logic [7:0]  slot_q [FRAME_BYTES];
   logic [7:0]  snap_v [FRAME_BYTES];

   generate
      if (ADDR_W == 16) begin : g_pc_full
         assign pc16 = pc_in;
      end else begin : g_pc_ext
         assign pc16 = {{(16-ADDR_W){1'b0}}, pc_in};
      end
   endgenerate

   always_comb begin
      snap_v[SLOT_PCL] = pc16[7:0];
      snap_v[SLOT_PCH] = pc16[15:8];
      snap_v[SLOT_YL]  = y_in[7:0];
      snap_v[SLOT_YH]  = y_in[15:8];
      snap_v[SLOT_XL]  = x_in[7:0];
      snap_v[SLOT_XH]  = x_in[15:8];
      snap_v[SLOT_A]   = a_in;
      snap_v[SLOT_B]   = b_in;
      snap_v[SLOT_CC]  = cc_in;
   end

   always_ff @(posedge clk) begin
      for (int s = 0; s < FRAME_BYTES; s++) begin
         if (snap)
            slot_q[s] <= snap_v[s];
         else if (cap && cap_slot == SLOT_W'(s))
            slot_q[s] <= cap_byte;
      end
   end

   assign rd_byte = (rd_slot < SLOT_W'(FRAME_BYTES)) ? slot_q[rd_slot] : 8'h00;
   assign x_out   = {slot_q[SLOT_XH], slot_q[SLOT_XL]};
   assign y_out   = {slot_q[SLOT_YH], slot_q[SLOT_YL]};
   assign a_out   = slot_q[SLOT_A];
   assign b_out   = slot_q[SLOT_B];
   assign cc_out  = slot_q[SLOT_CC];
   assign pc_hi   = slot_q[SLOT_PCH];
endmodule

// File: rtl/ctx_mask.sv
module ctx_mask #(
   parameter int unsigned I_POS = 4,
   parameter int unsigned X_POS = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sw_wr,
   input  logic [7:0] sw_data,
   input  logic       entry_set,
   input  logic       entry_nmi,
   input  logic       restore,
   input  logic [7:0] restore_data,
   output logic [7:0] ccr
);
   localparam logic [7:0] CC_RST = (8'd1 << I_POS) | (8'd1 << X_POS);

   logic [7:0] sw_next;

   always_comb begin
      sw_next        = sw_data;
      sw_next[X_POS] = ccr[X_POS] & sw_data[X_POS];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ccr <= CC_RST;
      end else if (restore) begin
         ccr <= restore_data;
      end else if (entry_set) begin
         ccr[I_POS] <= 1'b1;
         if (entry_nmi) ccr[X_POS] <= 1'b1;
      end else if (sw_wr) begin
         ccr <= sw_next;
      end
   end

   // R7
   x_no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ccr[X_POS] && !(entry_set && entry_nmi) && !restore) |=> !ccr[X_POS]);
endmodule

// File: rtl/ctx_seq.sv
module ctx_seq
   import ctx_seq_pkg::*;
#(
   parameter int unsigned ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_entry,
   input  logic              go_ret,
   input  logic              nmi,
   input  logic [ADDR_W-1:0] vec,
   input  logic              sp_wr,
   input  logic [ADDR_W-1:0] sp_wdata,
   input  logic [7:0]        mem_rdata,
   output seq_state_e        st,
   output logic [SLOT_W-1:0] idx,
   output logic [ADDR_W-1:0] sp,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic              mem_re,
   output logic [7:0]        vhi,
   output logic              nmi_q,
   output logic              push_last,
   output logic              pull_last,
   output logic              vlo_cyc,
   output logic              busy
);
   localparam logic [SLOT_W-1:0] LAST_IDX = SLOT_W'(FRAME_BYTES - 1);
   localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);

   logic [ADDR_W-1:0] vec_q;
   logic              at_last;

   assign at_last   = (idx == LAST_IDX);
   assign push_last = (st == SEQ_PUSH) && at_last;
   assign pull_last = (st == SEQ_PULL) && at_last;
   assign vlo_cyc   = (st == SEQ_VLO);
   assign busy      = (st != SEQ_IDLE);
   assign mem_we    = (st == SEQ_PUSH);
   assign mem_re    = (st == SEQ_PULL) || (st == SEQ_VHI) || (st == SEQ_VLO);

   always_comb begin
      unique case (st)
         SEQ_PUSH: mem_addr = sp - ONE;
         SEQ_VHI:  mem_addr = vec_q;
         SEQ_VLO:  mem_addr = vec_q + ONE;
         default:  mem_addr = sp;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= SEQ_IDLE;
         idx   <= '0;
         sp    <= '0;
         vec_q <= '0;
         nmi_q <= 1'b0;
         vhi   <= '0;
      end else begin
         unique case (st)
            SEQ_IDLE: begin
               idx <= '0;
               if (go_entry) begin
                  st    <= SEQ_PUSH;
                  vec_q <= vec;
                  nmi_q <= nmi;
               end else if (go_ret) begin
                  st <= SEQ_PULL;
               end else if (sp_wr) begin
                  sp <= sp_wdata;
               end
            end
            SEQ_PUSH: begin
               sp <= sp - ONE;
               if (at_last) st <= SEQ_VHI;
               else         idx <= idx + 1'b1;
            end
            SEQ_VHI: begin
               vhi <= mem_rdata;
               st  <= SEQ_VLO;
            end
            SEQ_VLO: st <= SEQ_IDLE;
            SEQ_PULL: begin
               sp <= sp + ONE;
               if (at_last) st <= SEQ_IDLE;
               else         idx <= idx + 1'b1;
            end
            default: st <= SEQ_IDLE;
         endcase
      end
   end

   // R4
   push_sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (sp == $past(mem_addr)));

   // R8
   pull_sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SEQ_PULL) |=> (sp == $past(mem_addr) + ONE));

   // R10
   push_uninterrupted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == SEQ_PUSH) && !at_last) |=> (st == SEQ_PUSH));
endmodule

// File: rtl/irq_ctx_stacker.sv
module irq_ctx_stacker
   import ctx_seq_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned I_POS  = 4,
   parameter int unsigned X_POS  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_done,
   input  logic              irq_req,
   input  logic              irq_nmi,
   input  logic [ADDR_W-1:0] irq_vec,
   input  logic              rti_req,
   input  logic              sp_wr,
   input  logic [ADDR_W-1:0] sp_wdata,
   output logic [ADDR_W-1:0] sp,
   input  logic              ccr_wr,
   input  logic [7:0]        ccr_wdata,
   output logic [7:0]        ccr,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [15:0]       x_in,
   input  logic [15:0]       y_in,
   input  logic [7:0]        a_in,
   input  logic [7:0]        b_in,
   output logic              pc_load,
   output logic [ADDR_W-1:0] pc_new,
   output logic              regs_load,
   output logic [15:0]       x_out,
   output logic [15:0]       y_out,
   output logic [7:0]        a_out,
   output logic [7:0]        b_out,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic              mem_re,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   output logic              busy
);
   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_aw
         $error("irq_ctx_stacker: ADDR_W must lie in 9..16");
      end
      if (I_POS > 7 || X_POS > 7 || I_POS == X_POS) begin : g_bad_pos
         $error("irq_ctx_stacker: mask positions must be distinct and below 8");
      end
   endgenerate

   seq_state_e        st;
   logic [SLOT_W-1:0] idx;
   logic [7:0]        vhi, pc_hi, cc_frame;
   logic              nmi_q, push_last, pull_last, vlo_cyc;
   logic              irq_ok, go_entry, go_ret;
   logic [15:0]       pc16_new;

   assign irq_ok   = irq_req && insn_done && (irq_nmi ? !ccr[X_POS] : !ccr[I_POS]);
   assign go_ret   = !busy && rti_req;
   assign go_entry = !busy && irq_ok && !rti_req;

   ctx_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .go_entry  (go_entry),
      .go_ret    (go_ret),
      .nmi       (irq_nmi),
      .vec       (irq_vec),
      .sp_wr     (sp_wr),
      .sp_wdata  (sp_wdata),
      .mem_rdata (mem_rdata),
      .st        (st),
      .idx       (idx),
      .sp        (sp),
      .mem_addr  (mem_addr),
      .mem_we    (mem_we),
      .mem_re    (mem_re),
      .vhi       (vhi),
      .nmi_q     (nmi_q),
      .push_last (push_last),
      .pull_last (pull_last),
      .vlo_cyc   (vlo_cyc),
      .busy      (busy)
   );

   ctx_frame #(.ADDR_W(ADDR_W)) u_frame (
      .clk      (clk),
      .snap     (go_entry),
      .pc_in    (pc_in),
      .x_in     (x_in),
      .y_in     (y_in),
      .a_in     (a_in),
      .b_in     (b_in),
      .cc_in    (ccr),
      .cap      (st == SEQ_PULL),
      .cap_slot (SLOT_W'(FRAME_BYTES - 1) - idx),
      .cap_byte (mem_rdata),
      .rd_slot  (idx),
      .rd_byte  (mem_wdata),
      .x_out    (x_out),
      .y_out    (y_out),
      .a_out    (a_out),
      .b_out    (b_out),
      .cc_out   (cc_frame),
      .pc_hi    (pc_hi)
   );

   ctx_mask #(.I_POS(I_POS), .X_POS(X_POS)) u_mask (
      .clk          (clk),
      .rst_n        (rst_n),
      .sw_wr        (ccr_wr && !busy),
      .sw_data      (ccr_wdata),
      .entry_set    (push_last),
      .entry_nmi    (nmi_q),
      .restore      (pull_last),
      .restore_data (cc_frame),
      .ccr          (ccr)
   );

   assign pc_load   = vlo_cyc || pull_last;
   assign regs_load = pull_last;
   assign pc16_new  = vlo_cyc ? {vhi, mem_rdata} : {pc_hi, mem_rdata};
   assign pc_new    = pc16_new[ADDR_W-1:0];

   // R5
   entry_sets_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_load && !regs_load) |-> ccr[I_POS]);

   // R9
   restore_ccr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      regs_load |=> (ccr == $past(cc_frame)));

   // R10
   busy_holds_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mem_we && !(mem_re && !vlo_cyc && st != SEQ_VHI)) |=> $stable(sp));
endmodule

// File: tb/tb_irq_ctx_stacker.sv
`timescale 1ns/1ps
module tb_irq_ctx_stacker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_done = 1'b0, irq_req = 1'b0, irq_nmi = 1'b0, rti_req = 1'b0;
   logic [15:0] irq_vec = 16'h0;
   logic        sp_wr = 1'b0;
   logic [15:0] sp_wdata = 16'h0;
   logic [15:0] sp;
   logic        ccr_wr = 1'b0;
   logic [7:0]  ccr_wdata = 8'h0;
   logic [7:0]  ccr;
   logic [15:0] pc_in = 16'h0, x_in = 16'h0, y_in = 16'h0;
   logic [7:0]  a_in = 8'h0, b_in = 8'h0;
   logic        pc_load, regs_load, mem_we, mem_re, busy;
   logic [15:0] pc_new, x_out, y_out, mem_addr;
   logic [7:0]  a_out, b_out, mem_wdata, mem_rdata;

   logic [7:0]  mem [1024];
   int          n_chk = 0, n_err = 0, n_pcload = 0;
   logic [15:0] cap_pc, cap_x, cap_y;
   logic [7:0]  cap_a, cap_b;

   always #2 clk = ~clk;

   irq_ctx_stacker dut (
      .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .irq_req(irq_req),
      .irq_nmi(irq_nmi), .irq_vec(irq_vec), .rti_req(rti_req), .sp_wr(sp_wr),
      .sp_wdata(sp_wdata), .sp(sp), .ccr_wr(ccr_wr), .ccr_wdata(ccr_wdata),
      .ccr(ccr), .pc_in(pc_in), .x_in(x_in), .y_in(y_in), .a_in(a_in),
      .b_in(b_in), .pc_load(pc_load), .pc_new(pc_new), .regs_load(regs_load),
      .x_out(x_out), .y_out(y_out), .a_out(a_out), .b_out(b_out),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy)
   );

   assign mem_rdata = mem[mem_addr[9:0]];
   always @(posedge clk) if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;

   always @(negedge clk) begin
      if (pc_load) begin
         cap_pc = pc_new;
         n_pcload++;
      end
      if (regs_load) begin
         cap_x = x_out; cap_y = y_out; cap_a = a_out; cap_b = b_out;
      end
   end

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1", "ccr after reset", ccr, 8'h50);
      check("R1", "busy after reset", busy, 1'b0);
      check("R1", "no write after reset", mem_we, 1'b0);
   endtask

   task automatic t_masked_at_reset();
      insn_done = 1'b1; irq_req = 1'b1; irq_nmi = 1'b0;
      repeat (3) @(negedge clk);
      check("R2", "maskable ignored with I set", busy, 1'b0);
      irq_nmi = 1'b1;
      repeat (3) @(negedge clk);
      check("R2", "non-maskable ignored with X set", busy, 1'b0);
      irq_req = 1'b0; irq_nmi = 1'b0;
   endtask

   task automatic t_sw_ccr();
      ccr_wr = 1'b1; ccr_wdata = 8'h00;
      @(negedge clk);
      check("R7", "ccr cleared", ccr, 8'h00);
      ccr_wdata = 8'hFF;
      @(negedge clk);
      check("R7", "X not set by software", ccr, 8'hBF);
      ccr_wdata = 8'h0F;
      @(negedge clk);
      ccr_wr = 1'b0;
      check("R7", "ccr written", ccr, 8'h0F);
      sp_wr = 1'b1; sp_wdata = 16'h0200;
      @(negedge clk);
      sp_wr = 1'b0;
      check("R4", "stack pointer loaded", sp, 16'h0200);
   endtask

   task automatic do_entry(input logic nmi, input logic [15:0] vec,
                           input logic [7:0] pre_cc, input logic [7:0] post_cc,
                           input logic [15:0] exp_pc, input logic [15:0] sp0);
      int n = 0;
      int loads0 = n_pcload;
      logic [7:0] exp_b [9];
      exp_b[0] = pc_in[7:0]; exp_b[1] = pc_in[15:8];
      exp_b[2] = y_in[7:0];  exp_b[3] = y_in[15:8];
      exp_b[4] = x_in[7:0];  exp_b[5] = x_in[15:8];
      exp_b[6] = a_in;       exp_b[7] = b_in;
      exp_b[8] = pre_cc;
      insn_done = 1'b0; irq_req = 1'b1; irq_nmi = nmi; irq_vec = vec;
      repeat (2) @(negedge clk);
      check("R3", "no entry without instruction end", busy, 1'b0);
      insn_done = 1'b1;
      @(negedge clk);
      check("R3", "busy one cycle after accept", busy, 1'b1);
      irq_req = 1'b0; irq_nmi = 1'b0;
      while (busy === 1'b1 && n < 40) begin
         n++;
         if (n == 3) begin
            irq_req = 1'b1; irq_nmi = 1'b1; rti_req = 1'b1;
            sp_wr = 1'b1; sp_wdata = 16'h0123;
            ccr_wr = 1'b1; ccr_wdata = 8'h00;
         end else if (n == 4) begin
            irq_req = 1'b0; irq_nmi = 1'b0; rti_req = 1'b0;
            sp_wr = 1'b0; ccr_wr = 1'b0;
         end
         @(negedge clk);
      end
      check("R6", "entry busy cycles", n, 11);
      check("R6", "one pc load on entry", n_pcload - loads0, 1);
      check("R6", "vector loaded", cap_pc, exp_pc);
      check("R4", "sp after entry", sp, sp0 - 16'd9);
      check("R10", "no second frame started", busy, 1'b0);
      for (int k = 0; k < 9; k++)
         check("R4", $sformatf("stack byte %0d", k), mem[10'(sp0 - 16'(k) - 16'd1)], exp_b[k]);
      check("R5", "ccr after entry", ccr, post_cc);
   endtask

   task automatic do_return(input logic [15:0] e_pc, input logic [15:0] e_x,
                            input logic [15:0] e_y, input logic [7:0] e_a,
                            input logic [7:0] e_b, input logic [7:0] e_cc,
                            input logic [15:0] e_sp);
      int n = 0;
      int loads0 = n_pcload;
      rti_req = 1'b1;
      @(negedge clk);
      rti_req = 1'b0;
      check("R8", "busy after return command", busy, 1'b1);
      while (busy === 1'b1 && n < 40) begin
         n++;
         @(negedge clk);
      end
      check("R8", "return busy cycles", n, 9);
      check("R8", "sp after return", sp, e_sp);
      check("R9", "one pc load on return", n_pcload - loads0, 1);
      check("R9", "pc restored", cap_pc, e_pc);
      check("R9", "x restored", cap_x, e_x);
      check("R9", "y restored", cap_y, e_y);
      check("R9", "a restored", cap_a, e_a);
      check("R9", "b restored", cap_b, e_b);
      check("R9", "ccr restored", ccr, e_cc);
   endtask

   task automatic t_maskable_round_trip();
      pc_in = 16'h4321; x_in = 16'hA1B2; y_in = 16'hC3D4; a_in = 8'h11; b_in = 8'h22;
      do_entry(1'b0, 16'h03F0, 8'h0F, 8'h1F, 16'h1234, 16'h0200);
      irq_req = 1'b1; irq_nmi = 1'b0; insn_done = 1'b1;
      repeat (3) @(negedge clk);
      irq_req = 1'b0;
      check("R2", "maskable ignored inside handler", busy, 1'b0);
      mem[10'h1F9] <= 8'h5A;
      @(negedge clk);
      do_return(16'h4321, 16'hA1B2, 16'hC3D4, 8'h5A, 8'h22, 8'h0F, 16'h0200);
   endtask

   task automatic t_nmi_round_trip();
      pc_in = 16'h0777; x_in = 16'h1357; y_in = 16'h2468; a_in = 8'h9A; b_in = 8'hBC;
      do_entry(1'b1, 16'h03F4, 8'h0F, 8'h5F, 16'hABCD, 16'h0200);
      irq_req = 1'b1; irq_nmi = 1'b1; insn_done = 1'b1;
      repeat (3) @(negedge clk);
      irq_req = 1'b0; irq_nmi = 1'b0;
      check("R2", "non-maskable ignored inside its handler", busy, 1'b0);
      do_return(16'h0777, 16'h1357, 16'h2468, 8'h9A, 8'hBC, 8'h0F, 16'h0200);
   endtask

   task automatic t_rti_precedence();
      irq_req = 1'b1; irq_nmi = 1'b1; rti_req = 1'b1; insn_done = 1'b1;
      @(negedge clk);
      irq_req = 1'b0; irq_nmi = 1'b0; rti_req = 1'b0;
      check("R10", "return wins: no write in first cycle", mem_we, 1'b0);
      check("R10", "return wins: reading stack", mem_re, 1'b1);
      repeat (12) @(negedge clk);
      check("R10", "sp after lone return", sp, 16'h0209);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] <= 8'h00;
      mem[10'h3F0] <= 8'h12; mem[10'h3F1] <= 8'h34;
      mem[10'h3F4] <= 8'hAB; mem[10'h3F5] <= 8'hCD;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_masked_at_reset();
      t_sw_ccr();
      t_maskable_round_trip();
      t_nmi_round_trip();
      t_rti_precedence();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule